// File: doc/BRIEF.md
# Bank-Selectable Output Range Limiter

This block clamps signed results into a window before they leave a processing pipeline. It has two independent channels, A and B. Each channel owns a bank of sixteen window descriptors. A 4-bit selector, sampled together with each result, picks the descriptor that applies to that result. The selector can change on every clock, so two or more streams that share a channel in alternate cycles can each be held to their own range.

Each descriptor is one 32-bit word that holds an upper and a lower bound. A result below the lower bound leaves as the lower bound. A result above the upper bound leaves as the upper bound. Anything else passes through unchanged. Each channel has an enable. When it is clear, the channel passes results through untouched and only adds its register stage.

Software loads the descriptors through a plain write port, one per channel. It is expected to keep the upper bound above the lower bound. After reset every descriptor spans the full signed range, so the channel has no effect until windows are loaded.

Top module: `orl_range_limiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both outputs read zero and both valid flags are low. Every descriptor resets to lower bound 0x8000 and upper bound 0x7FFF, so any 16-bit input passes through unchanged until a descriptor is loaded.
- R2: A write on a channel's port with the write enable high stores the 32-bit word in the descriptor named by the 4-bit write address. Bits 31:16 hold the upper bound and bits 15:0 hold the lower bound, both 16-bit two's complement.
- R3: The 4-bit selector presented with a sample chooses descriptor n for selector value n (0 to 15). The chosen window applies to that same sample, and the selector may differ on every cycle.
- R4: With limiting enabled, a valid input strictly below the selected lower bound produces the lower bound.
- R5: With limiting enabled, a valid input strictly above the selected upper bound produces the upper bound.
- R6: With limiting enabled, a valid input within the selected window, bounds included, is output unchanged.
- R7: `limit_en` bit 1 enables limiting on channel A and bit 0 enables it on channel B. While a channel's bit is 0, its input passes to its output unchanged whatever window is selected.
- R8: The output and its valid flag appear exactly one clock after the input. When the input valid flag is low, the output valid goes low and the output keeps its previous value.
- R9: If a descriptor is written in the same cycle that it is selected, that cycle's sample uses the old contents. The new contents apply from the next cycle.
- R10: The two channels are independent. A write on one channel's port never changes the window seen by the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| limit_en | input | 2 | Limit enables: bit 1 is channel A, bit 0 is channel B |
| a_wr_en | input | 1 | Channel A descriptor write strobe |
| a_wr_addr | input | 4 | Channel A descriptor index to write |
| a_wr_data | input | 32 | Channel A descriptor word {upper, lower} |
| a_sel | input | 4 | Channel A per-sample descriptor selector |
| a_in | input | 16 | Channel A signed input result |
| a_in_vld | input | 1 | Channel A input valid |
| a_out | output | 16 | Channel A clamped result |
| a_out_vld | output | 1 | Channel A output valid |
| b_wr_en | input | 1 | Channel B descriptor write strobe |
| b_wr_addr | input | 4 | Channel B descriptor index to write |
| b_wr_data | input | 32 | Channel B descriptor word {upper, lower} |
| b_sel | input | 4 | Channel B per-sample descriptor selector |
| b_in | input | 16 | Channel B signed input result |
| b_in_vld | input | 1 | Channel B input valid |
| b_out | output | 16 | Channel B clamped result |
| b_out_vld | output | 1 | Channel B output valid |

## Verification
Two functions can land in the same cycle: a descriptor write and a sample that selects the same descriptor. The bench provokes this on purpose. It loads a window, then rewrites that index with a much narrower window while a sample that falls between the two windows selects it. The result must follow the old window, and the same input one cycle later must follow the new one. The behavioural model works this out by computing each expected value before it applies that cycle's write. The same ordering covers writes on one channel that coincide with samples on the other channel using the same index.

// File: rtl/orl_pkg.sv
package orl_pkg;

   // Channel numbering used across the limiter
   typedef enum logic [0:0] {
      CH_A = 1'b0,
      CH_B = 1'b1
   } orl_chan_e;

   localparam int unsigned ORL_CHANNELS = 2;

   // Which limit_en bit belongs to a channel (A uses the upper bit)
   function automatic int unsigned orl_en_bit(input int unsigned ch);
      return ORL_CHANNELS - 1 - ch;
   endfunction

endpackage

// File: rtl/orl_limit_bank.sv
module orl_limit_bank #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned SEL_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_addr,
   input  logic [2*DATA_W-1:0]        wr_data,
   input  logic [SEL_W-1:0]           rd_sel,
   output logic signed [DATA_W-1:0]   rd_lo,
   output logic signed [DATA_W-1:0]   rd_hi
);

   localparam int unsigned WORD_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] LO_RST = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] HI_RST = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] WORD_RST = {HI_RST, LO_RST};

   generate
      if (ENTRIES != (1 << SEL_W)) begin : g_bad_depth
         $error("orl_limit_bank: ENTRIES must equal 2**SEL_W");
      end
   endgenerate

   logic [WORD_W-1:0] rows [ENTRIES];

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rows[i] <= WORD_RST;
            end else if (wr_en && (wr_addr == SEL_W'(i))) begin
               rows[i] <= wr_data;
            end
         end
      end
   endgenerate

   // Read sees pre-write contents in a cycle that also writes (R9)
   logic [WORD_W-1:0] rd_word;
   assign rd_word = rows[rd_sel];
   assign rd_hi   = $signed(rd_word[WORD_W-1:DATA_W]);
   assign rd_lo   = $signed(rd_word[DATA_W-1:0]);

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rows[$past(wr_addr)] == $past(wr_data)));

   a_r9_old_word_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == rd_sel) && (rd_word != wr_data))
      |=> (rows[$past(rd_sel)] != $past(rd_word)));

endmodule

// File: rtl/orl_clamp_stage.sv
module orl_clamp_stage #(
   parameter int unsigned DATA_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic signed [DATA_W-1:0]  in_data,
   input  logic                      in_vld,
   input  logic signed [DATA_W-1:0]  lo,
   input  logic signed [DATA_W-1:0]  hi,
   output logic signed [DATA_W-1:0]  out_data,
   output logic                      out_vld
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("orl_clamp_stage: DATA_W must be at least 2");
      end
   endgenerate

   logic                     under;
   logic                     over;
   logic signed [DATA_W-1:0] picked;

   always_comb begin
      under  = in_data < lo;
      over   = in_data > hi;
      picked = in_data;
      if (en) begin
         if (under)     picked = lo;
         else if (over) picked = hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_data <= picked;
      end
   end

   a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && en && (in_data < lo)) |=> (out_data == $past(lo)));

   a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && en && (in_data > hi) && (lo <= hi)) |=> (out_data == $past(hi)));

   a_r6_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (in_data >= lo) && (in_data <= hi)) |=> (out_data == $past(in_data)));

   a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !en) |=> (out_data == $past(in_data)));

   a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(out_data)));

endmodule

// File: rtl/orl_range_limiter.sv
module orl_range_limiter #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned SEL_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                limit_en,
   input  logic                      a_wr_en,
   input  logic [SEL_W-1:0]          a_wr_addr,
   input  logic [2*DATA_W-1:0]       a_wr_data,
   input  logic [SEL_W-1:0]          a_sel,
   input  logic signed [DATA_W-1:0]  a_in,
   input  logic                      a_in_vld,
   output logic signed [DATA_W-1:0]  a_out,
   output logic                      a_out_vld,
   input  logic                      b_wr_en,
   input  logic [SEL_W-1:0]          b_wr_addr,
   input  logic [2*DATA_W-1:0]       b_wr_data,
   input  logic [SEL_W-1:0]          b_sel,
   input  logic signed [DATA_W-1:0]  b_in,
   input  logic                      b_in_vld,
   output logic signed [DATA_W-1:0]  b_out,
   output logic                      b_out_vld
);
   import orl_pkg::*;

   localparam int unsigned NCH    = ORL_CHANNELS;
   localparam int unsigned WORD_W = 2 * DATA_W;

   generate
      if (ENTRIES != (1 << SEL_W)) begin : g_bad_cfg
         $error("orl_range_limiter: ENTRIES must equal 2**SEL_W");
      end
   endgenerate

   logic                     ch_wr_en   [NCH];
   logic [SEL_W-1:0]         ch_wr_addr [NCH];
   logic [WORD_W-1:0]        ch_wr_data [NCH];
   logic [SEL_W-1:0]         ch_sel     [NCH];
   logic signed [DATA_W-1:0] ch_in      [NCH];
   logic                     ch_in_vld  [NCH];
   logic signed [DATA_W-1:0] ch_lo      [NCH];
   logic signed [DATA_W-1:0] ch_hi      [NCH];
   logic signed [DATA_W-1:0] ch_out     [NCH];
   logic                     ch_out_vld [NCH];

   always_comb begin
      ch_wr_en[CH_A]   = a_wr_en;
      ch_wr_addr[CH_A] = a_wr_addr;
      ch_wr_data[CH_A] = a_wr_data;
      ch_sel[CH_A]     = a_sel;
      ch_in[CH_A]      = a_in;
      ch_in_vld[CH_A]  = a_in_vld;
      ch_wr_en[CH_B]   = b_wr_en;
      ch_wr_addr[CH_B] = b_wr_addr;
      ch_wr_data[CH_B] = b_wr_data;
      ch_sel[CH_B]     = b_sel;
      ch_in[CH_B]      = b_in;
      ch_in_vld[CH_B]  = b_in_vld;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         orl_limit_bank #(
            .DATA_W  (DATA_W),
            .ENTRIES (ENTRIES),
            .SEL_W   (SEL_W)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_wr_en[c]),
            .wr_addr (ch_wr_addr[c]),
            .wr_data (ch_wr_data[c]),
            .rd_sel  (ch_sel[c]),
            .rd_lo   (ch_lo[c]),
            .rd_hi   (ch_hi[c])
         );

         orl_clamp_stage #(
            .DATA_W (DATA_W)
         ) u_clamp (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (limit_en[orl_en_bit(c)]),
            .in_data  (ch_in[c]),
            .in_vld   (ch_in_vld[c]),
            .lo       (ch_lo[c]),
            .hi       (ch_hi[c]),
            .out_data (ch_out[c]),
            .out_vld  (ch_out_vld[c])
         );
      end
   endgenerate

   assign a_out     = ch_out[CH_A];
   assign a_out_vld = ch_out_vld[CH_A];
   assign b_out     = ch_out[CH_B];
   assign b_out_vld = ch_out_vld[CH_B];

   // R10: traffic on B's write port leaves A's output path untouched
   a_r10_isolated_a: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr_en && !a_wr_en && a_in_vld && !limit_en[1]) |=> (a_out == $past(a_in)));

   a_r1_first_cycle_idle: assert property (@(posedge clk)
      !rst_n |=> (!a_out_vld && !b_out_vld));

endmodule

// File: tb/orl_range_limiter_bench.sv
module orl_range_limiter_bench;

   localparam int DW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        limit_en = 2'b00;
   logic              a_wr_en = 0, b_wr_en = 0;
   logic [3:0]        a_wr_addr = 0, b_wr_addr = 0;
   logic [31:0]       a_wr_data = 0, b_wr_data = 0;
   logic [3:0]        a_sel = 0, b_sel = 0;
   logic signed [15:0] a_in = 0, b_in = 0;
   logic              a_in_vld = 0, b_in_vld = 0;
   logic signed [15:0] a_out, b_out;
   logic              a_out_vld, b_out_vld;

   always #2 clk = ~clk;   // 250 MHz

   orl_range_limiter u_orl_range_limiter (
      .clk(clk), .rst_n(rst_n), .limit_en(limit_en),
      .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
      .a_sel(a_sel), .a_in(a_in), .a_in_vld(a_in_vld),
      .a_out(a_out), .a_out_vld(a_out_vld),
      .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
      .b_sel(b_sel), .b_in(b_in), .b_in_vld(b_in_vld),
      .b_out(b_out), .b_out_vld(b_out_vld)
   );

   // Behavioural reference: per-channel window tables as integers
   int lo_tab [2][16];
   int hi_tab [2][16];
   int exp_out [2];
   bit exp_vld [2];
   int vectors = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R1";

   function automatic int clampv(int v, int lo, int hi, bit en);
      if (!en) return v;
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic logic [31:0] pack(int lo, int hi);
      logic [15:0] l, h;
      l = 16'(lo);
      h = 16'(hi);
      return {h, l};
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         for (int i = 0; i < 16; i++) begin
            lo_tab[c][i] = -32768;
            hi_tab[c][i] = 32767;
         end
         exp_out[c] = 0;
         exp_vld[c] = 0;
      end
   endtask

   task automatic compare();
      vectors++;
      if (a_out_vld !== exp_vld[0] || (exp_vld[0] && int'(a_out) != exp_out[0])) begin
         errors++;
         $display("FAIL %s chA: got vld=%0b out=%0d expected vld=%0b out=%0d",
                  tag, a_out_vld, a_out, exp_vld[0], exp_out[0]);
      end
      vectors++;
      if (b_out_vld !== exp_vld[1] || (exp_vld[1] && int'(b_out) != exp_out[1])) begin
         errors++;
         $display("FAIL %s chB: got vld=%0b out=%0d expected vld=%0b out=%0d",
                  tag, b_out_vld, b_out, exp_vld[1], exp_out[1]);
      end
   endtask

   // Called just after a negedge with the stimulus already set
   task automatic tick();
      // expected results use the window as it was before this cycle's write (R9)
      exp_vld[0] = a_in_vld;
      if (a_in_vld)
         exp_out[0] = clampv(int'(a_in), lo_tab[0][a_sel], hi_tab[0][a_sel], limit_en[1]);
      exp_vld[1] = b_in_vld;
      if (b_in_vld)
         exp_out[1] = clampv(int'(b_in), lo_tab[1][b_sel], hi_tab[1][b_sel], limit_en[0]);
      if (a_wr_en) begin
         lo_tab[0][a_wr_addr] = int'($signed(a_wr_data[15:0]));
         hi_tab[0][a_wr_addr] = int'($signed(a_wr_data[31:16]));
      end
      if (b_wr_en) begin
         lo_tab[1][b_wr_addr] = int'($signed(b_wr_data[15:0]));
         hi_tab[1][b_wr_addr] = int'($signed(b_wr_data[31:16]));
      end
      @(negedge clk);
      compare();
      a_wr_en = 0;
      b_wr_en = 0;
   endtask

   task automatic idle_inputs();
      a_in_vld = 0; b_in_vld = 0; a_wr_en = 0; b_wr_en = 0;
   endtask

   task automatic sample(bit ch, int v, int s);
      if (ch == 0) begin a_in = 16'(v); a_sel = 4'(s); a_in_vld = 1; end
      else         begin b_in = 16'(v); b_sel = 4'(s); b_in_vld = 1; end
   endtask

   task automatic write_win(bit ch, int idx, int lo, int hi);
      if (ch == 0) begin a_wr_en = 1; a_wr_addr = 4'(idx); a_wr_data = pack(lo, hi); end
      else         begin b_wr_en = 1; b_wr_addr = 4'(idx); b_wr_data = pack(lo, hi); end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      // R1: outputs idle while in reset
      tag = "R1";
      repeat (3) @(negedge clk);
      compare();
      rst_n = 1;
      // R1: reset windows span full range, enables on
      limit_en = 2'b11;
      sample(0, -32768, 0); sample(1, 32767, 15); tick();
      sample(0, 32767, 7);  sample(1, -32768, 3); tick();
      idle_inputs();

      // R2: load windows into both banks, index = window identity
      tag = "R2";
      for (int i = 0; i < 16; i++) begin
         write_win(0, i, -100 * (i + 1), 50 * (i + 1));
         write_win(1, i, -10 * i - 5, 20 * i + 7);
         tick();
      end

      // R3/R4/R5/R6: selector moves every cycle
      for (int i = 0; i < 16; i++) begin
         tag = "R4"; sample(0, -30000, i); sample(1, -30000, 15 - i); tick();
         tag = "R5"; sample(0, 30000, i);  sample(1, 30000, i);      tick();
         tag = "R6"; sample(0, -100 * (i + 1), i); sample(1, 20 * i + 7, i); tick();
         tag = "R3"; sample(0, 50 * (i + 1), i); sample(1, 3, (i * 7) % 16); tick();
      end

      // R7: enable bit mapping
      tag = "R7";
      for (int e = 0; e < 4; e++) begin
         limit_en = 2'(e);
         sample(0, 25000, 2); sample(1, -25000, 2); tick();
         sample(0, -25000, 9); sample(1, 25000, 9); tick();
      end
      limit_en = 2'b11;

      // R8: gaps in valid; outputs must hold
      tag = "R8";
      sample(0, 40, 4); sample(1, -40, 4); tick();
      idle_inputs(); a_in = 16'sd999; b_in = -16'sd999; tick(); tick();
      sample(0, -7000, 1); tick();
      idle_inputs(); tick();

      // R9: write and select the same index in the same cycle
      tag = "R9";
      write_win(0, 5, -1000, 1000); write_win(1, 6, -1000, 1000); tick();
      write_win(0, 5, -10, 10); sample(0, 500, 5);
      write_win(1, 6, -10, 10); sample(1, -500, 6); tick();
      sample(0, 500, 5); sample(1, -500, 6); tick();
      idle_inputs();

      // R10: write on one channel while the other reads the same index
      tag = "R10";
      write_win(0, 3, -5, 5); sample(1, 300, 3); tick();
      sample(1, 300, 3); sample(0, 300, 3); tick();
      write_win(1, 8, 0, 1); sample(0, -3000, 8); tick();
      sample(0, -3000, 8); sample(1, -3000, 8); tick();
      idle_inputs();

      // Mixed traffic touching every requirement
      tag = "R3";
      for (int k = 0; k < 400; k++) begin
         int lo, hi;
         lo = -int'($urandom_range(20000, 0));
         hi = lo + 1 + int'($urandom_range(20000, 0));
         if ($urandom_range(3, 0) == 0) write_win(0, int'($urandom_range(15, 0)), lo, hi);
         if ($urandom_range(3, 0) == 0) write_win(1, int'($urandom_range(15, 0)), hi - 30000, hi);
         limit_en = 2'($urandom_range(3, 0));
         a_in = 16'($urandom); b_in = 16'($urandom);
         a_sel = 4'($urandom); b_sel = 4'($urandom);
         a_in_vld = 1'($urandom); b_in_vld = 1'($urandom);
         tick();
      end
      idle_inputs();
      tick();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule